// File: doc/BRIEF.md
# Modulo-3 Trit Adder/Subtractor

This block adds or subtracts two balanced-free ternary digits (trits) modulo 3. Each trit travels on a two-bit binary code. The unused fourth code is flagged as an error. The block is meant for a checksum or scrambler path, where a ternary marker is mixed with a parity value that uses the same three-value code.

Subtraction has no negation unit of its own. When the subtract select is high, the two bits of the second operand are exchanged, and that operand then enters the same adder. This works because negation modulo 3 leaves 0 alone and swaps 1 with 2.

The sum logic is written so that it can never produce the illegal code for any legal operand pair. A parameter chooses between two output forms: a registered output with a synchronous reset, or a purely combinational output.

Top module: `trit_addsub`

## Requirements
- R1: Trit values 0, 1 and 2 use the codes 2'b00, 2'b01 and 2'b10. The code 2'b11 is illegal in either operand.
- R2: With `op_sub`=0 and legal operands, `out_sum` equals (a+b) mod 3 for all nine pairs. In particular 1+1=2, 1+2=0, 2+2=1, and the operation is commutative.
- R3: With `op_sub`=1 and legal operands, `out_sum` equals (a−b) mod 3, for example 0−1=2 and 1−2=2.
- R4: `out_sum` is never 2'b11.
- R5: If either operand is 2'b11 and `in_valid` is high, `out_err` is 1 and `out_sum` is 2'b00.
- R6: If an operand is 2'b11 while `in_valid` is low, `out_err` stays 0.
- R7: With `REG_OUT`=1, `out_valid`, `out_sum` and `out_err` appear one clock after the inputs. `out_valid` follows `in_valid` with the same latency. With `REG_OUT`=0, they follow the inputs in the same cycle.
- R8: When `rst_n` is low at a rising clock edge, the registered outputs are cleared: `out_valid`=0, `out_err`=0 and `out_sum`=2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands are valid this cycle |
| op_sub | input | 1 | 0 = add, 1 = subtract (a − b) |
| a_trit | input | 2 | First operand trit code |
| b_trit | input | 2 | Second operand trit code |
| out_valid | output | 1 | Result valid |
| out_sum | output | 2 | Result trit code |
| out_err | output | 1 | An operand carried the illegal code |

## Verification
The case that is hardest to reach is an illegal code presented while `in_valid` is low. In that case the error must stay quiet, but the forced-zero sum must still show up.

The sweep reaches this case by running every one of the sixteen operand code pairs, in both operations, once with `in_valid` high and once with it low. Each result is compared with a modulo-3 value computed in the bench.

A second instance built with the combinational output checks the same values in the same cycle. A reset is also applied in the middle of the run while an error-producing input is being held.

// File: rtl/trit_pkg.sv
// Shared constants for the trit arithmetic block.
// Assumes a trit is carried on two bits; code 2'b11 is illegal.
package trit_pkg;
    localparam int TRIT_W = 2;
    typedef logic [TRIT_W-1:0] trit_t;
    localparam trit_t TRIT_ZERO    = 2'b00;
    localparam trit_t TRIT_ONE     = 2'b01;
    localparam trit_t TRIT_TWO     = 2'b10;
    localparam trit_t TRIT_ILLEGAL = 2'b11;
endpackage

// File: rtl/trit_operand_prep.sv
// Prepares the operands: optionally negates the second trit by exchanging
// its two bits, and flags the illegal code on either operand.
// Assumes the exchange preserves 2'b00 and 2'b11, so detection is unaffected.
module trit_operand_prep
    import trit_pkg::*;
(
    input  trit_t a_in,
    input  trit_t b_in,
    input  logic  negate,
    output trit_t a_out,
    output trit_t b_out,
    output logic  illegal
);
    // Negate b when subtracting; flag any operand holding the fourth code.
    always_comb begin
        a_out   = a_in;
        b_out   = negate ? {b_in[0], b_in[1]} : b_in;
        illegal = (a_in == TRIT_ILLEGAL) || (b_in == TRIT_ILLEGAL);
    end
endmodule

// File: rtl/trit_add_core.sv
// Modulo-3 sum of two legal trits. Each sum bit is restricted to the
// operand pairs that truly produce it, so no legal pair can give 2'b11.
// Assumes the caller masks the result when an operand is illegal.
module trit_add_core
    import trit_pkg::*;
(
    input  trit_t x,
    input  trit_t y,
    output trit_t s
);
    // Bit 0 set for (0,1),(1,0),(2,2); bit 1 set for (0,2),(2,0),(1,1).
    always_comb begin
        s[0] = ((x[0] ^ y[0]) & ~x[1] & ~y[1]) | (x[1] & y[1]);
        s[1] = ((x[1] ^ y[1]) & ~x[0] & ~y[0]) | (x[0] & y[0]);
    end

    // Guard: legal operands never give the illegal code.
    always_comb begin
        if (!$isunknown({x, y}) && x != TRIT_ILLEGAL && y != TRIT_ILLEGAL)
            AST_SUM_LEGAL: assert (s != TRIT_ILLEGAL); // R4
    end
endmodule

// File: rtl/trit_out_stage.sv
// Output stage: a register with a synchronous active-low reset when
// REG_OUT is 1, otherwise a plain pass-through of the inputs.
module trit_out_stage
    import trit_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  d_valid,
    input  trit_t d_sum,
    input  logic  d_err,
    output logic  q_valid,
    output trit_t q_sum,
    output logic  q_err
);
    generate
        if (REG_OUT) begin : g_reg
            // Capture the result every clock; the reset clears everything.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q_valid <= 1'b0;
                    q_sum   <= TRIT_ZERO;
                    q_err   <= 1'b0;
                end else begin
                    q_valid <= d_valid;
                    q_sum   <= d_sum;
                    q_err   <= d_err;
                end
            end

            AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
                d_valid |=> q_valid); // R7
            AST_RESET_CLEARS: assert property (@(posedge clk)
                !rst_n |=> (!q_valid && !q_err && q_sum == TRIT_ZERO)); // R8
        end else begin : g_comb
            // No register: the result leaves in the same cycle.
            always_comb begin
                q_valid = d_valid;
                q_sum   = d_sum;
                q_err   = d_err;
            end
        end
    endgenerate
endmodule

// File: rtl/trit_addsub.sv
// Top level: modulo-3 add/subtract of two two-bit trits, with an illegal
// code check, a forced-zero result on error, and an optional output register.
// Assumes the codes 00/01/10 stand for 0/1/2.
module trit_addsub
    import trit_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                op_sub,
    input  logic [TRIT_W-1:0]   a_trit,
    input  logic [TRIT_W-1:0]   b_trit,
    output logic                out_valid,
    output logic [TRIT_W-1:0]   out_sum,
    output logic                out_err
);
    trit_t a_p, b_p, raw_sum, fin_sum;
    logic  bad, err_q;

    trit_operand_prep u_prep (
        .a_in    (a_trit),
        .b_in    (b_trit),
        .negate  (op_sub),
        .a_out   (a_p),
        .b_out   (b_p),
        .illegal (bad)
    );

    trit_add_core u_core (
        .x (a_p),
        .y (b_p),
        .s (raw_sum)
    );

    // Force zero on an illegal operand; raise the error only on valid input.
    always_comb begin
        fin_sum = bad ? TRIT_ZERO : raw_sum;
        err_q   = bad & in_valid;
    end

    trit_out_stage #(.REG_OUT(REG_OUT)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_valid (in_valid),
        .d_sum   (fin_sum),
        .d_err   (err_q),
        .q_valid (out_valid),
        .q_sum   (out_sum),
        .q_err   (out_err)
    );

    AST_NO_ILLEGAL_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_sum != TRIT_ILLEGAL); // R4
    AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> (out_sum == TRIT_ZERO && out_valid)); // R5
    AST_ERR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !out_err); // R6
endmodule

// File: tb/trit_addsub_bench.sv
`timescale 1ns/1ps
module trit_addsub_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, op_sub = 1'b0;
    logic [1:0] a_trit = 2'b00, b_trit = 2'b00;
    logic       r_valid, r_err, c_valid, c_err;
    logic [1:0] r_sum, c_sum;
    int         n_checks = 0, n_fail = 0;
    bit         finished = 1'b0;

    always #4 clk = ~clk;

    trit_addsub #(.REG_OUT(1'b1)) u_trit_addsub (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
        .a_trit(a_trit), .b_trit(b_trit),
        .out_valid(r_valid), .out_sum(r_sum), .out_err(r_err));

    trit_addsub #(.REG_OUT(1'b0)) u_trit_addsub_comb (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
        .a_trit(a_trit), .b_trit(b_trit),
        .out_valid(c_valid), .out_sum(c_sum), .out_err(c_err));

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    // Tag the check by what the case exercises.
    function automatic string tag(input bit v, input bit sub, input int a, input int b);
        if (a == 3 || b == 3) return v ? "R5" : "R6";
        return sub ? "R3" : "R2";
    endfunction

    task automatic apply(input bit v, input bit sub, input int a, input int b);
        bit         bad;
        int         e;
        logic [3:0] exp;
        bad = (a == 3) || (b == 3);
        e   = bad ? 0 : (sub ? (a + 3 - b) % 3 : (a + b) % 3);
        exp = {v, 1'(v && bad), 2'(e)};
        @(negedge clk);
        in_valid = v; op_sub = sub; a_trit = 2'(a); b_trit = 2'(b);
        #1;
        check({tag(v, sub, a, b), " R7 comb"}, {c_valid, c_err, c_sum}, exp);
        if (c_sum == 2'b11) check("R4", {2'b00, c_sum}, 4'b0000);
        @(negedge clk);
        check({tag(v, sub, a, b), " R7 reg"}, {r_valid, r_err, r_sum}, exp);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R8: reset clears the registered outputs even with error input held.
        in_valid = 1'b1; a_trit = 2'b11; b_trit = 2'b01;
        repeat (2) @(negedge clk);
        check("R8 reset", {r_valid, r_err, r_sum}, 4'b0000);
        rst_n = 1'b1;
        // R1 codes: operand values 0..2 on 00/01/10, 3 is the illegal code 11.
        for (int s = 0; s < 2; s++)
            for (int a = 0; a < 4; a++)
                for (int b = 0; b < 4; b++) begin
                    apply(1'b1, s[0], a, b);
                    apply(1'b0, s[0], a, b);
                end
        // R7: a valid pulse lasts exactly one cycle at the registered output.
        apply(1'b1, 1'b0, 1, 1);
        apply(1'b0, 1'b0, 2, 2);
        // R8: reset in the middle of the run, while an error is being driven.
        @(negedge clk);
        in_valid = 1'b1; op_sub = 1'b0; a_trit = 2'b01; b_trit = 2'b11;
        rst_n = 1'b0;
        @(negedge clk);
        check("R8 mid reset", {r_valid, r_err, r_sum}, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R5 after reset", {r_valid, r_err, r_sum}, 4'b1100);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule